// File: doc/BRIEF.md
# Arcade Video Timing Generator

This block produces the raster timing for a display whose line and frame lengths are not powers of two. A 9-bit horizontal counter advances on every clock of the 6 MHz pixel-pair clock, so its lowest bit toggles at 3 MHz. It runs up to a terminal value and then reloads an odd preset instead of wrapping through zero, which gives a 382-clock line. A 9-bit vertical counter advances once per line with the same reload scheme, which gives a 262-line frame.

Blanking and sync are not decoded from comparators. Each one is a flip-flop that changes state only when counter bit 4 (the "16" bit) of its counter rises, and the higher counter bits decide at that edge whether the flag is set or cleared. The counters themselves are output, so downstream pixel and fetch logic can decode their own fields from the same bits. All outputs are registered in the single clock domain and change on the same edge as the counter value they belong to.

Top module: `arcade_video_timing`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `h_count` to 0x081, `v_count` to 0x0F9, `hblank` and `vblank` to 0, and `hsync_n` and `vsync_n` to 1.
- R2: `h_count` increases by one on every clock edge, so bit 0 toggles every clock; after 0x1FE the next value is 0x081, giving a line period of exactly 382 clocks.
- R3: `hblank` is 1 exactly while `h_count` is in 0x090..0x0EF (96 clocks per line) and is never 1 while `h_count` bit 8 is 1.
- R4: `hsync_n` is 0 exactly while `h_count` is in 0x0B0..0x0CF (32 clocks per line), always inside the `hblank` interval.
- R5: `v_count` changes only on the edge where `h_count` goes from 0x1FE to 0x081; it then increases by one, except that after 0x1FE it loads 0x0F9, giving a frame of exactly 262 lines (100084 clocks).
- R6: After a vertical reload, `vsync_n` is 0 while `v_count` is in 0x0F9..0x0FF (7 lines, 2674 clocks) and 1 otherwise.
- R7: `vblank` rises when `v_count` becomes 0x1F0 and falls when `v_count` becomes 0x110, so it covers 38 lines (14516 clocks) and leaves 224 active lines.
- R8: After reset, `vsync_n` stays 1 and `vblank` stays 0 until their first setting edge (the first vertical reload and the first arrival at 0x1F0), even though the reset row lies inside both intervals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 6 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| h_count | output | 9 | Horizontal counter; bit 0 is the 3 MHz pixel bit, bit 8 is the inverted top bit (1 in the active half of the line) |
| v_count | output | 9 | Vertical counter; bit 8 is 0 during the first seven rows after reload |
| hblank | output | 1 | Horizontal blanking, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vblank | output | 1 | Vertical blanking, active high |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The block is driven from reset through one complete frame and into the next, so every horizontal line pattern is seen with the vertical counter at its reset row, in the middle of the active area, across the 0x1F0 blanking edge, across the reload and across the 0x110 end of blanking. Comparing each cycle against a range-based model tells a flag that is edge-triggered on the wrong counter bit, or decided by the wrong upper bits, apart from a correct one, because the boundary counts 0x090, 0x0B0, 0x0D0, 0x0F0 all share the same low bits. Separate run-length and period measurements tell an off-by-one preset or terminal value apart from a shifted window, and a second reset late in the run shows that the post-reset suppression of vertical sync and blanking repeats.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // counter width and the bit whose rising edge clocks every flag
  localparam int CW       = 9;
  localparam int EDGE_BIT = 4;

  typedef logic [CW-1:0] cnt_t;

  // next counter value: hold, reload at terminal, or count up
  function automatic cnt_t count_step(cnt_t cur, logic en, cnt_t term, cnt_t load);
    if (!en)         return cur;
    if (cur == term) return load;
    return cur + cnt_t'(1);
  endfunction

  // rising edge of the flag-clock bit between two successive counts
  function automatic logic edge_rise(cnt_t cur, cnt_t nxt);
    return !cur[EDGE_BIT] && nxt[EDGE_BIT];
  endfunction

  // horizontal blank: held off in the upper half, set on an edge
  // unless bits 5 and 6 are both high, which clears it
  function automatic logic hblank_step(cnt_t cur, cnt_t nxt, logic blank);
    if (nxt[CW-1])           return 1'b0;
    if (edge_rise(cur, nxt)) return !(nxt[EDGE_BIT+1] && nxt[EDGE_BIT+2]);
    return blank;
  endfunction

  // horizontal sync (active high internally): only inside blanking,
  // starts on an edge once blanking is already running, ends when bit 6 is high
  function automatic logic hsync_step(cnt_t cur, cnt_t nxt, logic blank_now,
                                      logic blank_next, logic sync);
    if (!blank_next)          return 1'b0;
    if (edge_rise(cur, nxt)) begin
      if (nxt[EDGE_BIT+2])    return 1'b0;
      if (blank_now)          return 1'b1;
    end
    return sync;
  endfunction

  // vertical blank: set on an edge with bits 5..7 all high, cleared with all low
  function automatic logic vblank_step(cnt_t cur, cnt_t nxt, logic blank);
    if (edge_rise(cur, nxt)) begin
      if (&nxt[EDGE_BIT+3:EDGE_BIT+1]) return 1'b1;
      if (~|nxt[EDGE_BIT+3:EDGE_BIT+1]) return 1'b0;
    end
    return blank;
  endfunction

  // vertical sync (active high internally): set by the reload, ended by bit 8
  function automatic logic vsync_step(logic reload, cnt_t nxt, logic sync);
    if (reload)    return 1'b1;
    if (nxt[CW-1]) return 1'b0;
    return sync;
  endfunction

endpackage

// File: rtl/vtg_counter.sv
module vtg_counter
  import vtg_pkg::*;
#(
  parameter cnt_t TERM = cnt_t'(9'h1FE),
  parameter cnt_t LOAD = cnt_t'(9'h081)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output cnt_t cnt,
  output cnt_t nxt,
  output logic wrap
);

  assign nxt  = count_step(cnt, en, TERM, LOAD);
  assign wrap = en && (cnt == TERM);

  always_ff @(posedge clk) begin
    if (rst) cnt <= LOAD;
    else     cnt <= nxt;
  end

endmodule

// File: rtl/vtg_h_flags.sv
module vtg_h_flags
  import vtg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cnt_t cur,
  input  cnt_t nxt,
  output logic blank,
  output logic sync
);

  logic blank_d;
  logic sync_d;

  always_comb begin
    blank_d = hblank_step(cur, nxt, blank);
    sync_d  = hsync_step(cur, nxt, blank, blank_d, sync);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blank <= 1'b0;
      sync  <= 1'b0;
    end else begin
      blank <= blank_d;
      sync  <= sync_d;
    end
  end

endmodule

// File: rtl/vtg_v_flags.sv
module vtg_v_flags
  import vtg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cnt_t cur,
  input  cnt_t nxt,
  input  logic reload,
  output logic blank,
  output logic sync
);

  always_ff @(posedge clk) begin
    if (rst) begin
      blank <= 1'b0;
      sync  <= 1'b0;
    end else begin
      blank <= vblank_step(cur, nxt, blank);
      sync  <= vsync_step(reload, nxt, sync);
    end
  end

endmodule

// File: rtl/arcade_video_timing.sv
module arcade_video_timing
  import vtg_pkg::*;
#(
  parameter logic [CW-1:0] H_TERM = 9'h1FE,
  parameter logic [CW-1:0] H_LOAD = 9'h081,
  parameter logic [CW-1:0] V_TERM = 9'h1FE,
  parameter logic [CW-1:0] V_LOAD = 9'h0F9
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] h_count,
  output logic [CW-1:0] v_count,
  output logic          hblank,
  output logic          hsync_n,
  output logic          vblank,
  output logic          vsync_n
);

  // named internal events, also observed by the bound checker
  cnt_t h_cnt, h_nxt;
  cnt_t v_cnt, v_nxt;
  logic h_wrap;
  logic v_wrap;
  logic hsync_act;
  logic vsync_act;

  vtg_counter #(.TERM(H_TERM), .LOAD(H_LOAD)) u_hcnt (
    .clk(clk), .rst(rst), .en(1'b1),
    .cnt(h_cnt), .nxt(h_nxt), .wrap(h_wrap)
  );

  vtg_counter #(.TERM(V_TERM), .LOAD(V_LOAD)) u_vcnt (
    .clk(clk), .rst(rst), .en(h_wrap),
    .cnt(v_cnt), .nxt(v_nxt), .wrap(v_wrap)
  );

  vtg_h_flags u_hflags (
    .clk(clk), .rst(rst), .cur(h_cnt), .nxt(h_nxt),
    .blank(hblank), .sync(hsync_act)
  );

  vtg_v_flags u_vflags (
    .clk(clk), .rst(rst), .cur(v_cnt), .nxt(v_nxt), .reload(v_wrap),
    .blank(vblank), .sync(vsync_act)
  );

  assign h_count = h_cnt;
  assign v_count = v_cnt;
  assign hsync_n = !hsync_act;
  assign vsync_n = !vsync_act;

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
#(
  parameter logic [CW-1:0] H_TERM = 9'h1FE,
  parameter logic [CW-1:0] H_LOAD = 9'h081,
  parameter logic [CW-1:0] V_TERM = 9'h1FE,
  parameter logic [CW-1:0] V_LOAD = 9'h0F9
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] h_count,
  input logic [CW-1:0] v_count,
  input logic          hblank,
  input logic          hsync_n,
  input logic          vblank,
  input logic          vsync_n,
  input logic          h_wrap,
  input logic          v_wrap
);

  assert_h_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    (h_count >= H_LOAD) && (h_count <= H_TERM));

  assert_h_step_R2: assert property (@(posedge clk) disable iff (rst)
    !h_wrap |=> (h_count == $past(h_count) + 9'd1));

  assert_h_reload_R2: assert property (@(posedge clk) disable iff (rst)
    h_wrap |=> (h_count == H_LOAD));

  assert_hblank_half_R3: assert property (@(posedge clk) disable iff (rst)
    hblank |-> !h_count[CW-1]);

  assert_hsync_in_blank_R4: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> hblank);

  assert_v_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !h_wrap |=> $stable(v_count));

  assert_v_reload_R5: assert property (@(posedge clk) disable iff (rst)
    v_wrap |=> (v_count == V_LOAD));

  assert_vsync_rows_R6: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> !v_count[CW-1]);

  assert_vblank_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> (v_count[7:4] == 4'hF));

  assert_vblank_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(vblank) |-> (v_count[7:4] == 4'h1));

endmodule

bind arcade_video_timing vtg_checker #(
  .H_TERM(H_TERM), .H_LOAD(H_LOAD), .V_TERM(V_TERM), .V_LOAD(V_LOAD)
) u_chk (
  .clk(clk), .rst(rst), .h_count(h_count), .v_count(v_count),
  .hblank(hblank), .hsync_n(hsync_n), .vblank(vblank), .vsync_n(vsync_n),
  .h_wrap(h_wrap), .v_wrap(v_wrap)
);

// File: tb/sim_arcade_video_timing.sv
`timescale 1ns/1ps
module sim_arcade_video_timing;

  localparam int CLK_PERIOD = 166;
  localparam int LINE_CLKS  = 382;
  localparam int FRAME_CLKS = 382 * 262;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] h_count, v_count;
  logic       hblank, hsync_n, vblank, vsync_n;

  arcade_video_timing u0 (
    .clk(clk), .rst(rst), .h_count(h_count), .v_count(v_count),
    .hblank(hblank), .hsync_n(hsync_n), .vblank(vblank), .vsync_n(vsync_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic       rs;
    logic [8:0] h;
    logic [8:0] v;
    logic       hb;
    logic       hs_n;
    logic       vb;
    logic       vs_n;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  logic done  = 1'b0;

  // bench model state, written from the requirement text
  logic [8:0] mh, mv;
  logic       m_seen_top;
  logic       m_reloaded;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic r);
    if (r) begin
      mh = 9'h081; mv = 9'h0F9; m_seen_top = 1'b0; m_reloaded = 1'b0;
    end else if (mh == 9'h1FE) begin
      mh = 9'h081;
      if (mv == 9'h1FE) begin
        mv = 9'h0F9; m_reloaded = 1'b1;
      end else begin
        mv = mv + 9'd1;
      end
    end else begin
      mh = mh + 9'd1;
    end
    if (mv == 9'h1F0) m_seen_top = 1'b1;
  endtask

  // driver: one clock edge, push what the ports must show after it
  task automatic tick();
    exp_t e;
    @(posedge clk);
    model_step(rst);
    e.rs   = rst;
    e.h    = mh;
    e.v    = mv;
    e.hb   = (mh >= 9'h090) && (mh <= 9'h0EF);
    e.hs_n = !((mh >= 9'h0B0) && (mh <= 9'h0CF));
    e.vb   = m_seen_top && ((mv >= 9'h1F0) || (mv < 9'h110));
    e.vs_n = !(m_reloaded && (mv < 9'h100));
    q.push_back(e);
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) tick();
    #1 rst = 1'b0;
    repeat (FRAME_CLKS + 9000) tick();
    #1 rst = 1'b1;
    repeat (3) tick();
    #1 rst = 1'b0;
    repeat (500) tick();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // monitor: pop and compare at the falling edge
  int         cyc;
  int         last_line;
  int         hb_run, hs_run, vb_run, vs_run;
  logic [8:0] prev_v;
  logic       prev_valid;

  initial begin
    cyc = 0; last_line = -1; hb_run = 0; hs_run = 0; vb_run = 0; vs_run = 0;
    prev_v = 9'h0; prev_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.rs) begin
          // R1 reset state
          check("R1 h_count", int'(h_count), int'(e.h));
          check("R1 v_count", int'(v_count), int'(e.v));
          check("R1 hblank",  int'(hblank),  0);
          check("R1 hsync_n", int'(hsync_n), 1);
          check("R1 vblank",  int'(vblank),  0);
          check("R1 vsync_n", int'(vsync_n), 1);
          cyc = 0; last_line = -1; hb_run = 0; hs_run = 0; vb_run = 0; vs_run = 0;
          prev_valid = 1'b0;
        end else begin
          cyc++;
          check("R2 h_count", int'(h_count), int'(e.h));
          check("R5 v_count", int'(v_count), int'(e.v));
          check("R3 hblank",  int'(hblank),  int'(e.hb));
          check("R4 hsync_n", int'(hsync_n), int'(e.hs_n));
          if (!m_seen_top) check("R8 vblank before first setting edge", int'(vblank), int'(e.vb));
          else             check("R7 vblank", int'(vblank), int'(e.vb));
          if (!m_reloaded) check("R8 vsync_n before first reload", int'(vsync_n), int'(e.vs_n));
          else             check("R6 vsync_n", int'(vsync_n), int'(e.vs_n));

          // R2 line period
          if (h_count == 9'h081) begin
            if (last_line >= 0) check("R2 line period", cyc - last_line, LINE_CLKS);
            last_line = cyc;
          end
          // R5 frame period, measured from reset row back to reset row
          if (prev_valid && (prev_v != 9'h0F9) && (v_count == 9'h0F9))
            check("R5 frame period", cyc, FRAME_CLKS);
          prev_v = v_count; prev_valid = 1'b1;

          // pulse widths
          if (hblank) hb_run++;
          else if (hb_run > 0) begin check("R3 hblank width", hb_run, 96); hb_run = 0; end
          if (!hsync_n) hs_run++;
          else if (hs_run > 0) begin check("R4 hsync width", hs_run, 32); hs_run = 0; end
          if (vblank) vb_run++;
          else if (vb_run > 0) begin check("R7 vblank width", vb_run, 38 * LINE_CLKS); vb_run = 0; end
          if (!vsync_n) vs_run++;
          else if (vs_run > 0) begin check("R6 vsync width", vs_run, 7 * LINE_CLKS); vs_run = 0; end
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d cycles", WATCHDOG, FRAME_CLKS + 9507);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule